// File: doc/BRIEF.md
# Serial flash wrapped-read sequencer

This block is the read engine on the memory side of a serial NOR flash. It keeps an 8-bit volatile settings register. A register-write command loads the register, and a register-read command returns its contents. When a fast-read command arrives with a start address, the engine first waits a programmed number of dummy clock cycles. It then streams one byte per clock from a small internal array. The stream is either sequential or wraps inside an aligned window of 16, 32 or 64 bytes.

Commands arrive on a single-cycle command strobe with an opcode, an address and a write byte. A level input keeps the read burst alive for as long as the host wants more data. Bytes leave on a byte bus with a byte-valid flag. Pin-level serial shifting is handled outside this block.

Top module: `flash_wrap_reader`

## Requirements
- R1: After reset the settings register reads 0xFB: dummy field 1111, bit 3 set, bit 2 clear, order field 11. `out_valid` and `cfg_rvalid` are low.
- R2: The opcode on `cmd_op` is 01 for a settings write, 10 for a settings read, 11 for a fast read, and 00 for no operation. A settings write stores `cmd_wdata`, except that bit 2 always reads back as 0. A settings read raises `cfg_rvalid` for one cycle on the clock edge after the command, with the current contents on `cfg_rdata`.
- R3: Bits 7:4 of the settings register are the dummy field. A field value N from 1 to 14 makes `out_valid` rise exactly N clock edges after the edge that accepts the fast read.
- R4: Field values 0000 and 1111 behave identically. Both give the default count, DUMMY_DEFAULT, which is 10.
- R5: Bits 1:0 of the settings register select the read order. The values 00, 01 and 10 wrap inside the aligned 16-, 32- or 64-byte block that holds the start address. The first byte comes from the start address, and the output never leaves that block.
- R6: Order value 11 reads sequentially. After the highest array index, the next index is 0.
- R7: With `cmd_wide` at 0, only bits 23:0 of `cmd_addr` form the address. With `cmd_wide` at 1, all 32 bits do. In both cases the array index is the address modulo the array size (256 bytes), and wrapping behaves the same.
- R8: When `cmd_active` is sampled low, the burst ends. `out_valid` is low from the next edge, and the engine then accepts a new command.
- R9: A command strobe that arrives while a fast read is in its dummy or data phase is ignored. The settings register does not change.
- R10: A settings write takes effect on the next fast read.
- R11: The byte at array index i is (7*i + 0x3C) mod 256. While `out_valid` is low, `out_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Opcode: 00 none, 01 settings write, 10 settings read, 11 fast read |
| cmd_addr | input | 32 | Fast-read start address |
| cmd_wide | input | 1 | 1 selects a 4-byte address, 0 a 3-byte address |
| cmd_wdata | input | 8 | Data for a settings write |
| cmd_active | input | 1 | Held high to keep a fast-read burst running |
| cfg_rvalid | output | 1 | Settings read data valid |
| cfg_rdata | output | 8 | Settings read data |
| out_valid | output | 1 | Read byte valid |
| out_byte | output | 8 | Read byte |

## Verification
The hardest case to reach from the ports is a wrap window that is crossed in the middle of a burst with a start address near the end of the block. The step back to the block base then happens after only one or two bytes. The bench starts bursts at the first, a middle and the last index of a block in each wrap mode. It runs each burst for longer than one full window, so every byte is compared against an independent address model. Command strobes injected during a data phase show, through a later settings read, that mid-burst commands are ignored.

// File: rtl/flash_wrap_pkg.sv
package flash_wrap_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_WRCFG = 2'b01,
    OP_RDCFG = 2'b10,
    OP_FREAD = 2'b11
  } fw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_DUMMY = 2'b01,
    ST_DATA  = 2'b10
  } fw_state_e;

  localparam logic [1:0] ORDER_W16 = 2'b00;
  localparam logic [1:0] ORDER_W32 = 2'b01;
  localparam logic [1:0] ORDER_W64 = 2'b10;
  localparam logic [1:0] ORDER_SEQ = 2'b11;

  localparam logic [7:0] CFG_RESET   = 8'hFB;
  localparam logic [7:0] CFG_RSVD_MASK = 8'hFB;

endpackage

// File: rtl/fwr_cfg_reg.sv
module fwr_cfg_reg
  import flash_wrap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] cfg_q
);

  logic [7:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data & CFG_RSVD_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= CFG_RESET;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[2] == 1'b0);

  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/fwr_dummy_ctr.sv
module fwr_dummy_ctr #(
  parameter int DUMMY_DEFAULT = 10,
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [3:0] code,
  input  logic       dec,
  output logic       done
);

  localparam logic [CNT_W-1:0] DEF_C = CNT_W'(DUMMY_DEFAULT);
  localparam logic [CNT_W-1:0] MAX_C = (DEF_C > CNT_W'(15)) ? DEF_C : CNT_W'(15);

  logic [CNT_W-1:0] cnt_q, cnt_d, span;

  always_comb begin
    if (code == 4'h0 || code == 4'hF) span = DEF_C;
    else                              span = CNT_W'(code);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load)                        cnt_d = span - CNT_W'(1);
    else if (dec && cnt_q != '0)     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load || dec)  cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < MAX_C);

  assert_load_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q + CNT_W'(1)) == $past(span));

endmodule

// File: rtl/fwr_addr_gen.sv
module fwr_addr_gen
  import flash_wrap_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    order_sel,
  input  logic          step,
  output logic [AW-1:0] addr_q
);

  // AW must be at least 6 so that the largest window fits in the array.
  logic [1:0]    order_q;
  logic [AW-1:0] mask, addr_d, addr_inc;

  always_comb begin
    unique case (order_q)
      ORDER_W16: mask = AW'(15);
      ORDER_W32: mask = AW'(31);
      ORDER_W64: mask = AW'(63);
      default:   mask = '1;
    endcase
  end

  assign addr_inc = addr_q + AW'(1);

  always_comb begin
    addr_d = addr_q;
    if (load)      addr_d = start_addr;
    else if (step) addr_d = (addr_q & ~mask) | (addr_inc & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      order_q <= ORDER_SEQ;
    end else begin
      if (load || step) addr_q <= addr_d;
      if (load)         order_q <= order_sel;
    end
  end

  assert_stay_in_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && order_q != ORDER_SEQ) |=>
      ((addr_q & ~$past(mask)) == ($past(addr_q) & ~$past(mask))));

  assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && order_q == ORDER_SEQ) |=> addr_q == $past(addr_inc));

endmodule

// File: rtl/flash_wrap_reader.sv
module flash_wrap_reader
  import flash_wrap_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int AW            = 8,
  parameter int DUMMY_DEFAULT = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_wide,
  input  logic [7:0]        cmd_wdata,
  input  logic              cmd_active,
  output logic              cfg_rvalid,
  output logic [7:0]        cfg_rdata,
  output logic              out_valid,
  output logic [7:0]        out_byte
);

  localparam int CNT_W = $clog2(((DUMMY_DEFAULT > 15) ? DUMMY_DEFAULT : 15) + 1);

  // Reset: asserted asynchronously, released through a flop chain.
  logic [SYNC_STAGES-1:0] rst_chain;
  logic rst_i_n;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_rsync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) rst_chain[gi] <= 1'b0;
          else        rst_chain[gi] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) rst_chain[gi] <= 1'b0;
          else        rst_chain[gi] <= rst_chain[gi-1];
        end
      end
    end
  endgenerate

  assign rst_i_n = rst_chain[SYNC_STAGES-1];

  fw_state_e state_q, state_d;
  logic [7:0] cfg_q;
  logic cfg_we, rd_req, rd_vld_q;
  logic [7:0] rd_data_q;
  logic burst_ld, addr_step, dummy_dec, dummy_done;
  logic [ADDR_W-1:0] eff_addr;
  logic [AW-1:0] addr_q;
  logic [7:0] rom_byte;

  assign eff_addr = cmd_wide ? cmd_addr : (cmd_addr & ADDR_W'(32'h00FF_FFFF));

  always_comb begin
    state_d   = state_q;
    cfg_we    = 1'b0;
    rd_req    = 1'b0;
    burst_ld  = 1'b0;
    addr_step = 1'b0;
    dummy_dec = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          unique case (fw_op_e'(cmd_op))
            OP_WRCFG: cfg_we = 1'b1;
            OP_RDCFG: rd_req = 1'b1;
            OP_FREAD: begin
              if (cmd_active) begin
                burst_ld = 1'b1;
                state_d  = ST_DUMMY;
              end
            end
            default: ;
          endcase
        end
      end
      ST_DUMMY: begin
        if (!cmd_active)     state_d = ST_IDLE;
        else if (dummy_done) state_d = ST_DATA;
        else                 dummy_dec = 1'b1;
      end
      ST_DATA: begin
        if (!cmd_active) state_d = ST_IDLE;
        else             addr_step = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= 8'h00;
    end else begin
      rd_vld_q <= rd_req;
      if (rd_req) rd_data_q <= cfg_q;
    end
  end

  fwr_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (cfg_we),
    .wr_data (cmd_wdata),
    .cfg_q   (cfg_q)
  );

  fwr_dummy_ctr #(.DUMMY_DEFAULT(DUMMY_DEFAULT), .CNT_W(CNT_W)) u_dummy (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (burst_ld),
    .code  (cfg_q[7:4]),
    .dec   (dummy_dec),
    .done  (dummy_done)
  );

  fwr_addr_gen #(.AW(AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load       (burst_ld),
    .start_addr (eff_addr[AW-1:0]),
    .order_sel  (cfg_q[1:0]),
    .step       (addr_step),
    .addr_q     (addr_q)
  );

  // Array contents are a computed pattern: 7*i + 0x3C.
  assign rom_byte = 8'(({{(8 > AW ? 8 - AW : 0){1'b0}}, addr_q} * 8'd7) + 8'h3C);

  assign out_valid  = (state_q == ST_DATA);
  assign out_byte   = out_valid ? rom_byte : 8'h00;
  assign cfg_rvalid = rd_vld_q;
  assign cfg_rdata  = rd_data_q;

  assert_data_after_dummy_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(out_valid) |-> $past(state_q) == ST_DUMMY);

  assert_stop_on_release_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cmd_active |=> !out_valid);

  assert_cfg_frozen_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != ST_IDLE) |=> $stable(cfg_q));

  assert_rvalid_cause_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    cfg_rvalid |-> $past(cmd_valid && cmd_op == OP_RDCFG && state_q == ST_IDLE));

endmodule

// File: tb/sim_flash_wrap_reader.sv
module sim_flash_wrap_reader;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic        cmd_wide;
  logic [7:0]  cmd_wdata;
  logic        cmd_active;
  logic        cfg_rvalid;
  logic [7:0]  cfg_rdata;
  logic        out_valid;
  logic [7:0]  out_byte;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  flash_wrap_reader u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wide(cmd_wide), .cmd_wdata(cmd_wdata),
    .cmd_active(cmd_active), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .out_valid(out_valid), .out_byte(out_byte)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int pat(input int idx);
    return (idx * 7 + 60) & 255;
  endfunction

  function automatic int nxt(input int a, input int mode);
    int w, base;
    if (mode == 3) return (a + 1) % 256;
    w = 16 << mode;
    base = a - (a % w);
    return base + ((a - base + 1) % w);
  endfunction

  function automatic int dummy_of(input int code);
    return (code == 0 || code == 15) ? 10 : code;
  endfunction

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_wdata = v;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic cfg_read(input string req, input int exp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    chk(cfg_rvalid == 1'b1, req, int'(cfg_rvalid), 1);
    chk(cfg_rdata == 8'(exp), req, int'(cfg_rdata), exp);
    @(negedge clk);
    chk(cfg_rvalid == 1'b0, req, int'(cfg_rvalid), 0);
  endtask

  // One burst: wait for the dummy phase, compare nbytes, then release.
  task automatic do_read(input logic [31:0] start, input bit wide, input int nbytes,
                         input int code, input int mode, input bit poke, input string req);
    int a, nd;
    nd = dummy_of(code);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = start; cmd_wide = wide;
    cmd_active = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    for (int k = 0; k < nd; k++) begin
      chk(out_valid == 1'b0, {req, " dummy"}, int'(out_valid), 0);
      @(negedge clk);
    end
    a = int'(start[7:0]);
    for (int j = 0; j < nbytes; j++) begin
      chk(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
      chk(out_byte == 8'(pat(a)), {req, " R11 byte"}, int'(out_byte), pat(a));
      a = nxt(a, mode);
      if (poke && j == 1) begin
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_wdata = 8'h00;
      end
      if (poke && j == 2) begin
        cmd_valid = 1'b0; cmd_op = 2'b00;
      end
      if (j < nbytes - 1) @(negedge clk);
    end
    cmd_active = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 end of burst", int'(out_valid), 0);
    chk(out_byte == 8'h00, "R11 idle byte", int'(out_byte), 0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(cfg_rvalid == 1'b0, "R1 cfg_rvalid", int'(cfg_rvalid), 0);
    cfg_read("R1 reset value", 8'hFB);
  endtask

  task automatic t_regs;
    cfg_write(8'hFF);
    cfg_read("R2 bit2 forced low", 8'hFB);
    cfg_write(8'h5A);
    cfg_read("R2 write readback", 8'h5A);
  endtask

  task automatic t_dummy;
    int codes[3] = '{1, 5, 14};
    foreach (codes[i]) begin
      cfg_write(8'({codes[i][3:0], 4'b1011}));
      do_read(32'h10, 1'b0, 3, codes[i], 3, 1'b0, "R3 R10 dummy N");
    end
    cfg_write(8'h0B);
    do_read(32'h20, 1'b0, 2, 0, 3, 1'b0, "R4 code 0000");
    cfg_write(8'hFB);
    do_read(32'h20, 1'b0, 2, 15, 3, 1'b0, "R4 code 1111");
  endtask

  task automatic t_wrap;
    for (int m = 0; m < 3; m++) begin
      int w;
      w = 16 << m;
      cfg_write(8'({4'd2, 2'b10, 2'(m)}));
      do_read(32'(64 + 0),       1'b0, w + 3, 2, m, 1'b0, "R5 wrap start");
      do_read(32'(128 + w / 2),  1'b1, w + 3, 2, m, 1'b0, "R5 wrap middle");
      do_read(32'(192 + w - 1),  1'b0, w + 3, 2, m, 1'b0, "R5 wrap end");
    end
  endtask

  task automatic t_seq;
    cfg_write(8'h2B);
    do_read(32'h0000_00FD, 1'b0, 6, 2, 3, 1'b0, "R6 rollover");
    do_read(32'h0000_0040, 1'b0, 20, 2, 3, 1'b0, "R6 sequential run");
  endtask

  task automatic t_width;
    cfg_write(8'h28);
    do_read(32'h7700_003B, 1'b0, 18, 2, 0, 1'b0, "R7 3-byte");
    do_read(32'hABCD_003B, 1'b1, 18, 2, 0, 1'b0, "R7 4-byte");
  endtask

  task automatic t_ignore;
    cfg_write(8'h39);
    do_read(32'h0000_0005, 1'b0, 5, 3, 1, 1'b1, "R9 burst with poke");
    cfg_read("R9 cfg unchanged", 8'h39);
    do_read(32'h0000_0007, 1'b0, 2, 3, 1, 1'b0, "R8 next command accepted");
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0;
    cmd_wide = 1'b0; cmd_wdata = 8'h00; cmd_active = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_dummy();
    t_wrap();
    t_seq();
    t_width();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule